// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block decides when an on-chip debugger should begin tracing and halt the processor. It watches match pulses from a set of bus comparators. Each match is qualified in one of two ways. A force match takes effect at the next instruction boundary. A tagged match takes effect only when the marked opcode reaches execution. Qualified matches walk a five-state machine. Software arms the machine into its first stage. Each of the three stages has its own programmable comparator selection and successor. Reaching the final stage raises a one-cycle trace-start pulse and a one-cycle halt request, each enabled separately. The halt request carries a type: either enter background debug or take a software interrupt.

A software trigger skips the comparators and sends an armed sequencer straight to the final stage. Disarming returns the machine to its idle state from any stage. While the machine is idle, every pending qualification is discarded.

States and transitions: IDLE (code 0) goes to STAGE1 on arm. STAGE1 (1), STAGE2 (2) and STAGE3 (3) each go to their programmed successor on a qualified match from their selected comparator, and go to FINAL on the software trigger. FINAL (4) holds until disarm. Disarm takes any state to IDLE.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset, state_o is 0 (IDLE), trace_start_o, brk_req_o and brk_type_o are 0, and no comparator qualification is pending.
- R2: In IDLE, arm_i moves state_o to 1 (STAGE1) at the next clock edge. In any other state, arm_i has no effect.
- R3: disarm_i returns state_o to IDLE at the next clock edge from every state. It overrides arm_i, trig_i and any qualified match in the same cycle.
- R4: In stage k (k = 1, 2, 3), comparator index seq_sel_i[2k-1:2k-2] is used. Its qualified match moves the state at the next edge to the successor coded in seq_next_i[2k-1:2k-2]. The successor codes are 0 for STAGE1, 1 for STAGE2, 2 for STAGE3 and 3 for FINAL. A successor equal to the current stage leaves the state unchanged.
- R5: A comparator whose cmp_tag_i bit is 0 works in force mode. A hit on its cmp_hit_i bit is held pending until the first boundary_i strobe in a later cycle. That strobe qualifies the match and clears the pending flag. A boundary in the same cycle as the hit does not count.
- R6: A comparator whose cmp_tag_i bit is 1 works in tagged mode. Its hit is held pending until exec_i qualifies it. boundary_i has no effect on it. flush_i discards the pending hit, so a later exec_i causes no transition.
- R7: trig_i moves STAGE1, STAGE2 or STAGE3 to FINAL at the next edge, whatever the comparators report. In IDLE, trig_i has no effect.
- R8: On each entry into FINAL, trace_start_o pulses for one cycle if trace_en_i is 1, and brk_req_o pulses for one cycle if brk_en_i is 1. The pulses occur in the first cycle in which state_o shows 4. FINAL then holds until disarm, and further triggers raise no pulse.
- R9: brk_type_o takes the value of brk_swi_i at each entry into FINAL (0 = background debug, 1 = software interrupt). It holds that value until the next entry.
- R10: A match from a comparator other than the current stage's selection has no effect, and so does a selection index of NUM_CMP or more.
- R11: Hits that occur while the sequencer is IDLE are discarded. They cannot qualify after a later arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Arm pulse (IDLE to STAGE1) |
| disarm_i | input | 1 | Disarm pulse, highest priority |
| trig_i | input | 1 | Software trigger pulse |
| cmp_hit_i | input | NUM_CMP | Comparator match pulses |
| cmp_tag_i | input | NUM_CMP | Per comparator: 1 tagged, 0 force |
| boundary_i | input | 1 | Instruction boundary strobe |
| exec_i | input | 1 | Tagged opcode reached execution |
| flush_i | input | 1 | Pipeline flush, drops tagged hits |
| seq_next_i | input | 6 | Successor code per stage, 2 bits each |
| seq_sel_i | input | 3*SEL_W | Comparator index per stage |
| trace_en_i | input | 1 | Enable trace start on FINAL entry |
| brk_en_i | input | 1 | Enable halt request on FINAL entry |
| brk_swi_i | input | 1 | Halt type to capture (1 software interrupt) |
| state_o | output | 3 | Current state code |
| trace_start_o | output | 1 | Trace start pulse |
| brk_req_o | output | 1 | Halt request pulse |
| brk_type_o | output | 1 | Captured halt type |

## Verification
The main walk drives a full chain from STAGE1 to FINAL with a mixed configuration. It tests a force match whose boundary comes in a later cycle, and a tagged match that is first offered a boundary and then an execute strobe. It also tests a hit that arrives in the same cycle as a boundary, which tells correct force timing apart from a design that qualifies too early. Further runs separate the selected comparator from unselected and out-of-range ones. They also separate a flushed tag from one that executes, a stale hit from the IDLE state from a fresh one, and a trigger when armed from one when disarmed. A direct jump to FINAL is compared with a self-loop. Halt type and pulse checks use both enable settings and both type values, so that a design that drops or repeats pulses can be told apart from a correct one.

// File: rtl/dts_pkg.sv
package dts_pkg;

    localparam int N_STAGE = 3;
    localparam int NXT_W   = 2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_STAGE1 = 3'd1,
        ST_STAGE2 = 3'd2,
        ST_STAGE3 = 3'd3,
        ST_FINAL  = 3'd4
    } seq_state_e;

    function automatic seq_state_e decode_next(input logic [NXT_W-1:0] code);
        seq_state_e s;
        unique case (code)
            2'd0:    s = ST_STAGE1;
            2'd1:    s = ST_STAGE2;
            2'd2:    s = ST_STAGE3;
            default: s = ST_FINAL;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dts_match_qual.sv
module dts_match_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic hit_i,
    input  logic tag_mode_i,
    input  logic boundary_i,
    input  logic exec_i,
    input  logic flush_i,
    output logic qual_o
);
    logic pend_q;
    logic strobe;
    logic drop;

    assign strobe = tag_mode_i ? exec_i : boundary_i;
    assign drop   = tag_mode_i & flush_i;
    assign qual_o = pend_q & strobe & ~drop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (clr_i)
            pend_q <= 1'b0;
        else
            pend_q <= hit_i | (pend_q & ~strobe & ~drop);
    end

    // R5: nothing pending and no new hit means no qualification next cycle
    a_r5_no_spurious_qual: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !hit_i) |=> !qual_o);

    // R6: a flushed tagged hit cannot qualify in the following cycle
    a_r6_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_mode_i && flush_i && !hit_i) |=> !qual_o);

    // R11: clearing while idle leaves nothing to qualify
    a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !qual_o);

endmodule

// File: rtl/dts_step.sv
module dts_step
    import dts_pkg::*;
#(
    parameter  int NUM_CMP = 3,
    localparam int SEL_W   = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  seq_state_e                  state_i,
    input  logic [NUM_CMP-1:0]          qual_i,
    input  logic [N_STAGE*NXT_W-1:0]    seq_next_i,
    input  logic [N_STAGE*SEL_W-1:0]    seq_sel_i,
    output logic                        step_o,
    output seq_state_e                  target_o
);
    logic [SEL_W-1:0] sel;
    logic [NXT_W-1:0] nxt;
    logic             active;
    logic             hit;

    always_comb begin
        sel    = '0;
        nxt    = '0;
        active = 1'b0;
        for (int k = 0; k < N_STAGE; k++) begin
            if (state_i == seq_state_e'(3'(k + 1))) begin
                active = 1'b1;
                sel    = seq_sel_i[k*SEL_W +: SEL_W];
                nxt    = seq_next_i[k*NXT_W +: NXT_W];
            end
        end
        hit = 1'b0;
        for (int c = 0; c < NUM_CMP; c++) begin
            if (sel == SEL_W'(c))
                hit = qual_i[c];
        end
        step_o   = active & hit;
        target_o = decode_next(nxt);
    end

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
    import dts_pkg::*;
#(
    parameter  int NUM_CMP = 3,
    localparam int SEL_W   = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     arm_i,
    input  logic                     disarm_i,
    input  logic                     trig_i,
    input  logic [NUM_CMP-1:0]       cmp_hit_i,
    input  logic [NUM_CMP-1:0]       cmp_tag_i,
    input  logic                     boundary_i,
    input  logic                     exec_i,
    input  logic                     flush_i,
    input  logic [N_STAGE*NXT_W-1:0] seq_next_i,
    input  logic [N_STAGE*SEL_W-1:0] seq_sel_i,
    input  logic                     trace_en_i,
    input  logic                     brk_en_i,
    input  logic                     brk_swi_i,
    output logic [2:0]               state_o,
    output logic                     trace_start_o,
    output logic                     brk_req_o,
    output logic                     brk_type_o
);
    seq_state_e         state_q;
    seq_state_e         state_d;
    seq_state_e         target;
    logic [NUM_CMP-1:0] qual;
    logic               step;
    logic               idle;
    logic               enter_final;

    assign idle = (state_q == ST_IDLE);

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_qual
        dts_match_qual u_qual (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr_i      (idle),
            .hit_i      (cmp_hit_i[c]),
            .tag_mode_i (cmp_tag_i[c]),
            .boundary_i (boundary_i),
            .exec_i     (exec_i),
            .flush_i    (flush_i),
            .qual_o     (qual[c])
        );
    end

    dts_step #(.NUM_CMP(NUM_CMP)) u_step (
        .state_i    (state_q),
        .qual_i     (qual),
        .seq_next_i (seq_next_i),
        .seq_sel_i  (seq_sel_i),
        .step_o     (step),
        .target_o   (target)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_i)
                    state_d = ST_STAGE1;
            end
            ST_STAGE1, ST_STAGE2, ST_STAGE3: begin
                if (trig_i)
                    state_d = ST_FINAL;
                else if (step)
                    state_d = target;
            end
            ST_FINAL: state_d = ST_FINAL;
            default:  state_d = ST_IDLE;
        endcase
        if (disarm_i)
            state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign enter_final = (state_d == ST_FINAL) && (state_q != ST_FINAL);

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trace_start_o <= 1'b0;
            brk_req_o     <= 1'b0;
            brk_type_o    <= 1'b0;
        end else begin
            trace_start_o <= enter_final & trace_en_i;
            brk_req_o     <= enter_final & brk_en_i;
            if (enter_final)
                brk_type_o <= brk_swi_i;
        end
    end

    assign state_o = state_q;

    // R3: disarm always wins
    a_r3_disarm_idle: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_i |=> state_q == ST_IDLE);

    // R2: arming from idle enters the first stage
    a_r2_arm_stage1: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && arm_i && !disarm_i) |=> state_q == ST_STAGE1);

    // R7: software trigger from an armed stage reaches final
    a_r7_trig_final: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && !disarm_i && !idle) |=> state_q == ST_FINAL);

    // R8: final holds until disarm
    a_r8_final_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINAL && !disarm_i) |=> state_q == ST_FINAL);

    // R8: halt request lasts one cycle
    a_r8_brk_single: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req_o |=> !brk_req_o);

    // R8: pulses appear only while final is shown
    a_r8_pulse_in_final: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req_o || trace_start_o) |-> state_q == ST_FINAL);

endmodule

// File: tb/test_dbg_trig_seq.sv
`timescale 1ns/1ps
module test_dbg_trig_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm_i = 1'b0, disarm_i = 1'b0, trig_i = 1'b0;
    logic [2:0] cmp_hit_i = '0;
    logic [2:0] cmp_tag_i = '0;
    logic       boundary_i = 1'b0, exec_i = 1'b0, flush_i = 1'b0;
    logic [5:0] seq_next_i = '0;
    logic [5:0] seq_sel_i = '0;
    logic       trace_en_i = 1'b0, brk_en_i = 1'b0, brk_swi_i = 1'b0;
    logic [2:0] state_o;
    logic       trace_start_o, brk_req_o, brk_type_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dbg_trig_seq i_dbg_trig_seq (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .disarm_i(disarm_i), .trig_i(trig_i),
        .cmp_hit_i(cmp_hit_i), .cmp_tag_i(cmp_tag_i), .boundary_i(boundary_i),
        .exec_i(exec_i), .flush_i(flush_i), .seq_next_i(seq_next_i), .seq_sel_i(seq_sel_i),
        .trace_en_i(trace_en_i), .brk_en_i(brk_en_i), .brk_swi_i(brk_swi_i),
        .state_o(state_o), .trace_start_o(trace_start_o), .brk_req_o(brk_req_o),
        .brk_type_o(brk_type_o)
    );

    // row: arm dis trig hit[2:0] bnd exe flush exp_state[2:0] exp_pulse
    localparam int NROW = 19;
    localparam logic [12:0] TBL [NROW] = '{
        13'b0_0_0_000_0_0_0_000_0,
        13'b1_0_0_000_0_0_0_001_0,
        13'b0_0_0_001_0_0_0_001_0,
        13'b0_0_0_000_1_0_0_010_0,
        13'b0_0_0_010_0_0_0_010_0,
        13'b0_0_0_000_1_0_0_010_0,
        13'b0_0_0_000_0_1_0_011_0,
        13'b0_0_0_100_1_0_0_011_0,
        13'b0_0_0_000_1_0_0_100_1,
        13'b0_0_0_000_0_0_0_100_0,
        13'b0_1_0_000_0_0_0_000_0,
        13'b0_0_0_001_0_0_0_000_0,
        13'b1_0_0_000_0_0_0_001_0,
        13'b0_0_0_000_1_0_0_001_0,
        13'b0_0_0_100_0_0_0_001_0,
        13'b0_0_0_000_1_0_0_001_0,
        13'b0_0_1_000_0_0_0_100_1,
        13'b1_1_0_000_0_0_0_000_0,
        13'b1_0_0_000_0_0_0_001_0
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // apply inputs for one cycle, then sample 1 ns after the edge
    task automatic step(input logic a, input logic d, input logic t, input logic [2:0] h,
                        input logic b, input logic e, input logic f);
        arm_i = a; disarm_i = d; trig_i = t; cmp_hit_i = h;
        boundary_i = b; exec_i = e; flush_i = f;
        @(posedge clk);
        #1;
        arm_i = 0; disarm_i = 0; trig_i = 0; cmp_hit_i = '0;
        boundary_i = 0; exec_i = 0; flush_i = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 state", state_o, 0);
        chk("R1 trace", trace_start_o, 0);
        chk("R1 brk", brk_req_o, 0);
        chk("R1 type", brk_type_o, 0);
        rst_n = 1'b1;

        // table walk: comp1 tagged, S1->S2 via c0, S2->S3 via c1, S3->FINAL via c2
        cmp_tag_i  = 3'b010;
        seq_next_i = 6'b11_10_01;
        seq_sel_i  = 6'b10_01_00;
        trace_en_i = 1; brk_en_i = 1; brk_swi_i = 1;
        for (int r = 0; r < NROW; r++) begin
            logic [12:0] v;
            v = TBL[r];
            step(v[12], v[11], v[10], v[9:7], v[6], v[5], v[4]);
            // R2 R3 R4 R5 R6 R7 R10 R11 covered by the row sequence
            chk($sformatf("R4 table row %0d state", r), state_o, int'(v[3:1]));
            chk($sformatf("R8 table row %0d trace", r), trace_start_o, int'(v[0]));
            chk($sformatf("R8 table row %0d brk", r), brk_req_o, int'(v[0]));
            if (r == 8) chk("R9 type after row 8", brk_type_o, 1);
        end

        // R2 arm ignored outside idle
        step(1, 0, 0, 3'b000, 0, 0, 0);
        chk("R2 arm in stage1", state_o, 1);

        // R6 flush drops a tagged hit
        step(0, 1, 0, 3'b000, 0, 0, 0);
        seq_sel_i = 6'b10_01_01;
        step(1, 0, 0, 3'b000, 0, 0, 0);
        step(0, 0, 0, 3'b010, 0, 0, 0);
        step(0, 0, 0, 3'b000, 0, 0, 1);
        step(0, 0, 0, 3'b000, 0, 1, 0);
        chk("R6 flushed tag", state_o, 1);
        step(0, 0, 0, 3'b010, 0, 0, 0);
        step(0, 0, 0, 3'b000, 0, 1, 0);
        chk("R6 executed tag", state_o, 2);

        // R4 direct jump to final and self loop
        step(0, 1, 0, 3'b000, 0, 0, 0);
        seq_sel_i  = 6'b10_01_00;
        seq_next_i = 6'b11_10_11;
        step(1, 0, 0, 3'b000, 0, 0, 0);
        step(0, 0, 0, 3'b001, 0, 0, 0);
        step(0, 0, 0, 3'b000, 1, 0, 0);
        chk("R4 direct final", state_o, 4);
        step(0, 1, 0, 3'b000, 0, 0, 0);
        seq_next_i = 6'b11_10_00;
        step(1, 0, 0, 3'b000, 0, 0, 0);
        step(0, 0, 0, 3'b001, 0, 0, 0);
        step(0, 0, 0, 3'b000, 1, 0, 0);
        chk("R4 self loop", state_o, 1);

        // R10 out-of-range selection
        seq_next_i = 6'b11_10_01;
        seq_sel_i  = 6'b10_01_11;
        step(0, 0, 0, 3'b111, 0, 0, 0);
        step(0, 0, 0, 3'b000, 1, 1, 0);
        chk("R10 sel out of range", state_o, 1);

        // R8 R9 halt only, software interrupt not selected
        step(0, 1, 0, 3'b000, 0, 0, 0);
        trace_en_i = 0; brk_en_i = 1; brk_swi_i = 0;
        step(1, 0, 0, 3'b000, 0, 0, 0);
        step(0, 0, 1, 3'b000, 0, 0, 0);
        chk("R7 trig final", state_o, 4);
        chk("R8 brk pulse", brk_req_o, 1);
        chk("R8 trace disabled", trace_start_o, 0);
        chk("R9 type bdm", brk_type_o, 0);
        step(0, 0, 0, 3'b000, 0, 0, 0);
        chk("R8 brk one cycle", brk_req_o, 0);
        brk_swi_i = 1;
        step(0, 0, 1, 3'b000, 0, 0, 0);
        chk("R8 no retrigger", brk_req_o, 0);
        chk("R9 type held", brk_type_o, 0);
        chk("R8 final holds", state_o, 4);

        // R7 trigger ignored while idle
        step(0, 1, 0, 3'b000, 0, 0, 0);
        step(0, 0, 1, 3'b000, 0, 0, 0);
        chk("R7 trig idle", state_o, 0);
        chk("R7 no pulse idle", brk_req_o, 0);

        // R8 R9 trace only, type captured even with halt disabled
        trace_en_i = 1; brk_en_i = 0;
        step(1, 0, 0, 3'b000, 0, 0, 0);
        step(0, 0, 1, 3'b000, 0, 0, 0);
        chk("R8 trace pulse", trace_start_o, 1);
        chk("R8 brk disabled", brk_req_o, 0);
        chk("R9 type swi", brk_type_o, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule